// File: doc/BRIEF.md
# Multichannel Sample Serializer with Frame and Bit Clocks

This block takes one parallel conversion result per channel for each sample period and sends it out serially, one bit per bit-clock cycle, on a separate one-bit lane per channel. All lanes share a frame clock that is high for the first half of every word and low for the second half. They also share a double-data-rate data clock whose edges fall in the middle of each bit, so a receiver can capture on both edges. A 14-bit word therefore spans seven data-clock periods.

The words can be formatted in several ways, chosen through plain configuration inputs. Conversion data can be sent as twos complement or as offset binary. Words can go out MSB-first or LSB-first, and their length can be cut to 12, 10 or 8 bits. A test source can replace the conversion data with one of three patterns: words that alternate between all ones and all zeros, a pseudorandom sequence, or a user word. Each lane can be powered down on its own. The block samples every data and configuration input only at the edge that loads a new word, so a word is never sent in a mixture of two formats. The bit-rate clock input runs at twice the data-clock frequency. It stands in for the clock multiplier.

Top module: `adc_lane_framer`

## Requirements
- R1: Each lane sends its channel's 14-bit word, one bit per bit-clock cycle. With lsb_first_i=0 the MSB goes first. A frame starts on the bit-clock edge after the previous frame's last bit.
- R2: The word length is 14 − 2·res_sel_i. frame_o is high during the first half of each word's bits and low during the second half.
- R3: dclk_o toggles on every falling edge of clk_bit while the block runs. It goes high in the middle of the first bit of every frame, which gives length/2 periods per frame.
- R4: With offset_bin_i=1 the MSB of the conversion data is inverted (offset binary). With offset_bin_i=0 the twos-complement data passes unchanged. Test patterns are never recoded.
- R5: With lsb_first_i=1 the sent bits run in reverse order, starting from the lowest bit of the kept field.
- R6: With a reduced length L, only the top L bits of the 14-bit word are sent: bits 13 down to 14−L.
- R7: test_sel_i selects the word source. 0 selects conversion data. 1 selects the alternating pattern: all ones in the first frame after reset, then the value flips every frame. 2 selects bits 13:0 of a 23-bit LFSR that is seeded to 1, steps as {s[21:0], s[22]^s[17]} once per frame, and is shared by all lanes. 3 selects user_word_i.
- R8: A lane whose pd_i bit is set holds lane_o low for the whole frame. The other lanes are unaffected.
- R9: Data and configuration inputs are sampled only at the frame-load edge. Changes made mid-frame have no effect until the next frame.
- R10: During reset lane_o, frame_o and dclk_o are low. The first frame loads on the first clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Bit-rate clock, one serial bit per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_i | input | CH*W | Conversion words, channel c at bits [c*W +: W] |
| offset_bin_i | input | 1 | 1 = offset binary, 0 = twos complement |
| lsb_first_i | input | 1 | 1 = LSB-first bit order |
| res_sel_i | input | 2 | Word length is W − 2·res_sel_i |
| test_sel_i | input | 2 | Word source: 0 data, 1 alternating, 2 pseudorandom, 3 user |
| user_word_i | input | W | User test word |
| pd_i | input | CH | Per-lane power-down |
| lane_o | output | CH | Serial data lanes |
| frame_o | output | 1 | Frame clock |
| dclk_o | output | 1 | DDR data clock, edges at mid-bit |

## Verification
The bench runs directed frames with distinct words per lane under each coding, bit order, resolution and test source. This separates an MSB inversion from a bit reversal and separates truncation at the top of the word from truncation at the bottom. Power-down is applied to a scattered set of lanes so that a wrong lane index shows up. Random frames then mix all settings. In every frame all inputs are scrambled mid-word, which exposes any input that is sampled outside the load edge. The alternating and pseudorandom models advance on every frame, so a source that steps only while it is selected is caught.

// File: rtl/adc_framer_pkg.sv
// Shared types and helpers for the multichannel serializer.
// Assumes a single bit-rate clock domain for all logic.
package adc_framer_pkg;

    localparam int PRBS_W = 23;

    // Word source selector
    typedef enum logic [1:0] {
        SRC_CONV   = 2'd0,
        SRC_TOGGLE = 2'd1,
        SRC_PRBS   = 2'd2,
        SRC_USER   = 2'd3
    } src_sel_e;

    // One step of the x^23 + x^18 + 1 Fibonacci LFSR
    function automatic logic [PRBS_W-1:0] prbs_step(input logic [PRBS_W-1:0] s);
        return {s[PRBS_W-2:0], s[22] ^ s[17]};
    endfunction

endpackage

// File: rtl/adc_frame_timer.sv
// Frame timer: counts bits within a word, issues the load strobe,
// drives the frame clock and the mid-bit DDR data clock.
// Assumes W is even and at least 8; the length is sampled only at load.
module adc_frame_timer #(
    parameter int W  = 14,
    localparam int CW = $clog2(W + 1)
) (
    input  logic          clk_bit,
    input  logic          rst_n,
    input  logic [1:0]    res_sel_i,
    output logic          load_o,
    output logic          run_o,
    output logic [CW-1:0] cnt_o,
    output logic [CW-1:0] len_o,
    output logic          frame_o,
    output logic          dclk_o
);
    logic          run_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] len_q;
    logic [CW-1:0] len_next;
    logic          dclk_q;

    // Word length chosen for the next frame
    always_comb len_next = CW'(W - 2 * int'(res_sel_i));

    // Load on the first edge after reset and after the last bit of each word
    always_comb load_o = !run_q || (cnt_q == len_q - CW'(1));

    // Bit counter, running flag and latched word length
    always_ff @(posedge clk_bit) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
            len_q <= CW'(W);
        end else if (load_o) begin
            run_q <= 1'b1;
            cnt_q <= '0;
            len_q <= len_next;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    // Data clock toggles on the falling edge, so its edges sit mid-bit
    always_ff @(negedge clk_bit) begin
        if (!rst_n) dclk_q <= 1'b0;
        else if (run_q) dclk_q <= ~dclk_q;
    end

    // Frame clock is high for the first half of the word
    always_comb frame_o = run_q && (cnt_q < (len_q >> 1));

    assign run_o  = run_q;
    assign cnt_o  = cnt_q;
    assign len_o  = len_q;
    assign dclk_o = dclk_q;

endmodule

// File: rtl/adc_pattern_src.sv
// Test word source shared by all lanes: alternating ones/zeros, LFSR
// pseudorandom word and user word. Both generators step once per frame
// regardless of the selected source. Assumes W <= 23.
module adc_pattern_src
    import adc_framer_pkg::*;
#(
    parameter int W = 14
) (
    input  logic         clk_bit,
    input  logic         rst_n,
    input  logic         load_i,
    input  src_sel_e     sel_i,
    input  logic [W-1:0] user_word_i,
    output logic [W-1:0] pat_o
);
    logic              alt_q;
    logic [PRBS_W-1:0] lfsr_q;

    // Advance both generators at every frame load
    always_ff @(posedge clk_bit) begin
        if (!rst_n) begin
            alt_q  <= 1'b1;
            lfsr_q <= PRBS_W'(1);
        end else if (load_i) begin
            alt_q  <= ~alt_q;
            lfsr_q <= prbs_step(lfsr_q);
        end
    end

    // Pick the test word for the frame being loaded
    always_comb begin
        case (sel_i)
            SRC_TOGGLE: pat_o = {W{alt_q}};
            SRC_PRBS:   pat_o = lfsr_q[W-1:0];
            SRC_USER:   pat_o = user_word_i;
            default:    pat_o = '0;
        endcase
    end

endmodule

// File: rtl/adc_lane_ser.sv
// One serial lane: formats a word (coding, source, bit order,
// truncation) at load and shifts it out MSB-of-register first.
// Power-down is latched at load with the word.
module adc_lane_ser #(
    parameter int W = 14
) (
    input  logic         clk_bit,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] sample_i,
    input  logic         use_conv_i,
    input  logic [W-1:0] pat_i,
    input  logic         offset_bin_i,
    input  logic         lsb_first_i,
    input  logic [1:0]   res_sel_i,
    input  logic         pd_i,
    output logic         ser_o,
    output logic         pd_o
);
    logic [W-1:0] src;
    logic [W-1:0] rev;
    logic [W-1:0] fmt;
    logic [W-1:0] sh_q;
    logic         pd_q;

    // Select source and apply output coding to conversion data only
    always_comb begin
        if (use_conv_i) src = {sample_i[W-1] ^ offset_bin_i, sample_i[W-2:0]};
        else            src = pat_i;
    end

    // Reverse and realign so the lowest kept bit leads in LSB-first order
    always_comb begin
        for (int i = 0; i < W; i++) rev[i] = src[W-1-i];
        fmt = lsb_first_i ? (rev << {res_sel_i, 1'b0}) : src;
    end

    // Load the formatted word at the boundary, else shift one bit
    always_ff @(posedge clk_bit) begin
        if (!rst_n) begin
            sh_q <= '0;
            pd_q <= 1'b0;
        end else if (load_i) begin
            sh_q <= fmt;
            pd_q <= pd_i;
        end else begin
            sh_q <= {sh_q[W-2:0], 1'b0};
        end
    end

    assign ser_o = sh_q[W-1];
    assign pd_o  = pd_q;

endmodule

// File: rtl/adc_lane_framer.sv
// Top: CH serial lanes sharing one frame timer and one test source.
// All configuration and data are sampled only at the frame-load edge.
module adc_lane_framer
    import adc_framer_pkg::*;
#(
    parameter int CH = 8,
    parameter int W  = 14
) (
    input  logic            clk_bit,
    input  logic            rst_n,
    input  logic [CH*W-1:0] sample_i,
    input  logic            offset_bin_i,
    input  logic            lsb_first_i,
    input  logic [1:0]      res_sel_i,
    input  logic [1:0]      test_sel_i,
    input  logic [W-1:0]    user_word_i,
    input  logic [CH-1:0]   pd_i,
    output logic [CH-1:0]   lane_o,
    output logic            frame_o,
    output logic            dclk_o
);
    localparam int CW = $clog2(W + 1);

    logic          load_w;
    logic          run_w;
    logic [CW-1:0] cnt_w;
    logic [CW-1:0] len_w;
    logic [W-1:0]  pat_w;
    logic [CH-1:0] ser_w;
    logic [CH-1:0] pd_q_w;
    src_sel_e      sel_w;

    assign sel_w = src_sel_e'(test_sel_i);

    adc_frame_timer #(.W(W)) u_timer (
        .clk_bit  (clk_bit),
        .rst_n    (rst_n),
        .res_sel_i(res_sel_i),
        .load_o   (load_w),
        .run_o    (run_w),
        .cnt_o    (cnt_w),
        .len_o    (len_w),
        .frame_o  (frame_o),
        .dclk_o   (dclk_o)
    );

    adc_pattern_src #(.W(W)) u_pat (
        .clk_bit    (clk_bit),
        .rst_n      (rst_n),
        .load_i     (load_w),
        .sel_i      (sel_w),
        .user_word_i(user_word_i),
        .pat_o      (pat_w)
    );

    for (genvar c = 0; c < CH; c++) begin : g_lane
        adc_lane_ser #(.W(W)) u_lane (
            .clk_bit     (clk_bit),
            .rst_n       (rst_n),
            .load_i      (load_w),
            .sample_i    (sample_i[c*W +: W]),
            .use_conv_i  (sel_w == SRC_CONV),
            .pat_i       (pat_w),
            .offset_bin_i(offset_bin_i),
            .lsb_first_i (lsb_first_i),
            .res_sel_i   (res_sel_i),
            .pd_i        (pd_i[c]),
            .ser_o       (ser_w[c]),
            .pd_o        (pd_q_w[c])
        );
        // Powered-down lane is held low
        assign lane_o[c] = ser_w[c] & ~pd_q_w[c];
    end

endmodule

// File: rtl/adc_lane_framer_chk.sv
// Checker for adc_lane_framer: frame, data clock, counter and
// power-down properties. Attached by bind below.
module adc_lane_framer_chk #(
    parameter int CH = 8,
    parameter int W  = 14,
    localparam int CW = $clog2(W + 1)
) (
    input logic          clk_bit,
    input logic          rst_n,
    input logic          load,
    input logic          run_q,
    input logic [CW-1:0] cnt_q,
    input logic [CW-1:0] len_q,
    input logic          frame_o,
    input logic          dclk_o,
    input logic [CH-1:0] pd_q,
    input logic [CH-1:0] lane_o
);
    // R2: frame clock is high in the first bit after every load
    p_frame_after_load_r2: assert property (@(posedge clk_bit) disable iff (!rst_n)
        load |=> frame_o);

    // R2: frame clock falls exactly at the word midpoint
    p_frame_fall_mid_r2: assert property (@(posedge clk_bit) disable iff (!rst_n)
        $fell(frame_o) |-> (cnt_q == (len_q >> 1)));

    // R3: data clock toggles once per bit while running
    p_dclk_toggle_r3: assert property (@(posedge clk_bit) disable iff (!rst_n)
        (run_q && $past(run_q)) |-> (dclk_o != $past(dclk_o)));

    // R3: data clock is high after the first bit of every frame
    p_dclk_phase_r3: assert property (@(posedge clk_bit) disable iff (!rst_n)
        load |=> dclk_o);

    // R6: bit counter stays within the latched word length
    p_cnt_bound_r6: assert property (@(posedge clk_bit) disable iff (!rst_n)
        run_q |-> (cnt_q < len_q));

    // R9: word length changes only across a load edge
    p_len_hold_r9: assert property (@(posedge clk_bit) disable iff (!rst_n)
        (len_q != $past(len_q)) |-> $past(load));

    // R8: a powered-down lane stays static
    for (genvar c = 0; c < CH; c++) begin : g_pd
        p_pd_static_r8: assert property (@(posedge clk_bit) disable iff (!rst_n)
            (pd_q[c] && $past(pd_q[c])) |-> $stable(lane_o[c]));
    end

endmodule

bind adc_lane_framer adc_lane_framer_chk #(.CH(CH), .W(W)) u_chk (
    .clk_bit(clk_bit),
    .rst_n  (rst_n),
    .load   (load_w),
    .run_q  (run_w),
    .cnt_q  (cnt_w),
    .len_q  (len_w),
    .frame_o(frame_o),
    .dclk_o (dclk_o),
    .pd_q   (pd_q_w),
    .lane_o (lane_o)
);

// File: tb/adc_lane_framer_test.sv
module adc_lane_framer_test;
    localparam int CH = 8;
    localparam int W  = 14;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [CH*W-1:0] sample;
    logic            offs, lsbf;
    logic [1:0]      res, tsel;
    logic [W-1:0]    uword;
    logic [CH-1:0]   pd;
    wire  [CH-1:0]   lane;
    wire             frame, dclk;

    always #4 clk = ~clk;

    adc_lane_framer #(.CH(CH), .W(W)) uut (
        .clk_bit(clk), .rst_n(rst_n), .sample_i(sample),
        .offset_bin_i(offs), .lsb_first_i(lsbf), .res_sel_i(res),
        .test_sel_i(tsel), .user_word_i(uword), .pd_i(pd),
        .lane_o(lane), .frame_o(frame), .dclk_o(dclk)
    );

    int          checks = 0;
    int          fails  = 0;
    bit          done   = 0;
    logic        m_alt  = 1'b1;
    logic [22:0] m_lfsr = 23'h1;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Word before truncation, from the requirements (R4, R7)
    function automatic logic [W-1:0] src_word(int c);
        logic [W-1:0] s;
        case (tsel)
            2'd0: begin s = sample[c*W +: W]; if (offs) s[W-1] = ~s[W-1]; end
            2'd1: s = {W{m_alt}};
            2'd2: s = m_lfsr[W-1:0];
            default: s = uword;
        endcase
        return s;
    endfunction

    // Expected serial sequence, first bit ends up most significant (R1, R5, R6, R8)
    function automatic logic [W-1:0] exp_seq(int c);
        int           len = W - 2 * int'(res);
        logic [W-1:0] w   = src_word(c);
        logic [W-1:0] q   = '0;
        if (pd[c]) return '0;
        for (int i = 0; i < len; i++)
            q = {q[W-2:0], lsbf ? w[W-len+i] : w[W-1-i]};
        return q;
    endfunction

    function automatic string tag(int c);
        if (pd[c])      return "R8";
        if (tsel != 0)  return "R7";
        if (lsbf)       return "R5";
        if (res != 0)   return "R6";
        if (offs)       return "R4";
        return "R1";
    endfunction

    task automatic set_cfg(input logic o, input logic l, input logic [1:0] r,
                           input logic [1:0] t, input logic [CH-1:0] p);
        offs = o; lsbf = l; res = r; tsel = t; pd = p;
        for (int c = 0; c < CH; c++) sample[c*W +: W] = W'($urandom);
        uword = W'($urandom);
    endtask

    // One frame: inputs are already set; sample each bit after the falling edge
    task automatic do_frame();
        logic [W-1:0] exp_l [CH];
        logic [W-1:0] got_l [CH];
        string        tg [CH];
        int           len = W - 2 * int'(res);
        logic [W-1:0] got_f = '0, exp_f = '0, got_d = '0, exp_d = '0;
        for (int c = 0; c < CH; c++) begin
            exp_l[c] = exp_seq(c); tg[c] = tag(c); got_l[c] = '0;
        end
        m_alt  = ~m_alt;
        m_lfsr = {m_lfsr[21:0], m_lfsr[22] ^ m_lfsr[17]};
        for (int i = 0; i < len; i++) begin
            @(posedge clk); #6;
            if (i == 2) begin
                // R9: scramble every input mid-word; this frame must not change
                set_cfg(1'($urandom), 1'($urandom), 2'($urandom), 2'($urandom), CH'($urandom));
            end
            for (int c = 0; c < CH; c++) got_l[c] = {got_l[c][W-2:0], lane[c]};
            got_f = {got_f[W-2:0], frame};
            exp_f = {exp_f[W-2:0], (i < len / 2) ? 1'b1 : 1'b0};
            got_d = {got_d[W-2:0], dclk};
            exp_d = {exp_d[W-2:0], (i % 2 == 0) ? 1'b1 : 1'b0};
        end
        for (int c = 0; c < CH; c++)
            chk(got_l[c] == exp_l[c], {"R9 ", tg[c], " lane"}, 32'(got_l[c]), 32'(exp_l[c]));
        chk(got_f == exp_f, "R2 frame", 32'(got_f), 32'(exp_f));
        chk(got_d == exp_d, "R3 dclk", 32'(got_d), 32'(exp_d));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd7);
        set_cfg(1'b0, 1'b0, 2'd0, 2'd0, '0);
        repeat (3) @(posedge clk);
        #6;
        // R10: outputs low during reset
        chk(lane == '0, "R10 lanes", 32'(lane), 0);
        chk(frame == 1'b0 && dclk == 1'b0, "R10 clocks", {frame, dclk}, 0);
        rst_n = 1'b1;
        // R10, R1: first frame loads right after reset, plain data
        set_cfg(1'b0, 1'b0, 2'd0, 2'd0, '0);
        do_frame();
        // R1 corner words
        set_cfg(1'b0, 1'b0, 2'd0, 2'd0, '0);
        sample[0 +: W] = 14'h2000; sample[W +: W] = 14'h0001; sample[2*W +: W] = 14'h3FFF;
        do_frame();
        set_cfg(1'b1, 1'b0, 2'd0, 2'd0, '0);   // R4 offset binary
        do_frame();
        set_cfg(1'b0, 1'b1, 2'd0, 2'd0, '0);   // R5 LSB-first
        do_frame();
        set_cfg(1'b0, 1'b0, 2'd3, 2'd0, '0);   // R6 8-bit words
        do_frame();
        set_cfg(1'b1, 1'b1, 2'd1, 2'd0, '0);   // R6 R5 12-bit LSB-first
        do_frame();
        set_cfg(1'b1, 1'b0, 2'd0, 2'd1, '0);   // R7 alternating, not recoded
        do_frame();
        set_cfg(1'b0, 1'b0, 2'd0, 2'd1, '0);
        do_frame();
        set_cfg(1'b0, 1'b0, 2'd2, 2'd2, '0);   // R7 pseudorandom
        do_frame();
        set_cfg(1'b0, 1'b1, 2'd0, 2'd3, '0);   // R7 user word
        do_frame();
        set_cfg(1'b0, 1'b0, 2'd0, 2'd0, 8'b1010_0101); // R8 power-down
        do_frame();
        for (int k = 0; k < 24; k++) begin
            set_cfg(1'($urandom), 1'($urandom), 2'($urandom), 2'($urandom), CH'($urandom & $urandom));
            do_frame();
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule